// File: doc/BRIEF.md
# Double-Buffered Octal Converter Register Front End

This block is the digital register front end of an eight-channel converter that has a parallel host bus. A host writes a 14-bit code, together with a 3-bit channel number, into one of eight staging registers. It does this with active-low select and write strobes. A separate active-low load strobe copies every staging register into its matching output register in one step. Holding load low all the time turns the block into a single-buffered part, where each write reaches its output register directly. An active-low clear strobe raises a clear flag on every channel. The analog stage uses that flag to park its output at the sense-ground level. The stored codes are not touched.

All four strobes, the channel number and the code are brought into the system clock domain through two-flop synchronizers. The rising edge of the write strobe is then detected in that domain. The channel number and the code travel down the same pipeline as the strobes, so they are taken from the last cycle in which the write strobe was seen low. The output side shows all eight output codes side by side in one flat vector, with channel `i` in bits `[14*i +: 14]`. It also shows one clear flag per channel.

Top module: `octal_dac_regif`

## Requirements
- R1: While `rst` is high and in the cycles right after it, every staging register and every output register reads zero and no clear flag is set.
- R2: A write happens when `wr_n` goes high after a stretch in which `cs_n` and `wr_n` were both low. The code is stored in the staging register whose index equals `chan_addr`, and only in that one.
- R3: A `wr_n` pulse taken while `cs_n` is high stores nothing in any staging register.
- R4: While `ld_n` is high, no output register changes, even when writes take place. While `ld_n` is low, all eight output registers take the contents of their staging registers at the same time.
- R5: With `ld_n` held low, a completed write to channel `c` shows up on channel `c` of `dac_code`.
- R6: Bit 13 of `wr_data` is the most significant bit and bit 0 the least. The code for channel `i` appears unchanged, bit for bit, in `dac_code[14*i +: 14]`.
- R7: While `clr_n` is low, every bit of `clr_flag` is 1. While it is high, every bit is 0. The flags follow `clr_n` two clock cycles later.
- R8: A clear leaves staging and output registers unchanged. After `clr_n` rises, every channel again shows the code it held before the clear, and a later load moves the staging contents that were there before the clear.
- R9: If the load strobe is active in the same cycle that a write completes, the output register of the written channel takes the newly written code, not the previous staging value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low; the code is taken on its rising edge |
| ld_n | input | 1 | Load strobe, active low, level sensitive |
| clr_n | input | 1 | Clear strobe, active low, level sensitive |
| chan_addr | input | 3 | Target channel of a write |
| wr_data | input | 14 | Code to write; bit 13 is the MSB |
| dac_code | output | 112 | Eight output-register codes; channel i in bits [14*i +: 14] |
| clr_flag | output | 8 | Per-channel clear flag for the analog stage |

## Verification
The properties assume the following about the inputs:
- `clr_n` is high throughout reset, so that the two-cycle relation between the clear strobe and the flags holds from the first cycle.
- `chan_addr` and `wr_data` stay stable from before `wr_n` falls until well after it rises, so the pipelined copies line up with the detected edge.

The stimulus holds every strobe level for at least three clock cycles. The one exception is a single-cycle load pulse that is placed deliberately in the same cycle as the rising edge of `wr_n`, to hit the coincident case. Every input changes at the falling clock edge, away from the sampling edge.

// File: rtl/octal_dac_pkg.sv
package octal_dac_pkg;

  // One-hot decode of a channel index: bit i is set when fire is high and idx equals i.
  function automatic logic chan_hit(input int unsigned idx, input int unsigned i,
                                    input logic fire);
    return fire && (idx == i);
  endfunction

  // Value an output register takes in a load cycle: a write completing in that
  // cycle takes priority over the old staging contents.
  function automatic logic [31:0] load_source(input logic [31:0] staged,
                                              input logic [31:0] fresh,
                                              input logic hit);
    return hit ? fresh : staged;
  endfunction

endpackage

// File: rtl/odr_sync.sv
module odr_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= {W{RST_V}};
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/odr_write_detect.sv
module odr_write_detect #(
  parameter int DATA_W = 14,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              wr_n_s,
  input  logic [CH_W-1:0]   addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              wr_commit,
  output logic [CH_W-1:0]   wr_ch,
  output logic [DATA_W-1:0] wr_word
);
  logic              wr_n_d;
  logic              cs_n_d;
  logic [CH_W-1:0]   addr_d;
  logic [DATA_W-1:0] data_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n_d <= 1'b1;
      cs_n_d <= 1'b1;
      addr_d <= '0;
      data_d <= '0;
    end else begin
      wr_n_d <= wr_n_s;
      cs_n_d <= cs_n_s;
      addr_d <= addr_s;
      data_d <= data_s;
    end
  end

  // Rising edge of write, with select low in the last cycle write was low.
  assign wr_commit = wr_n_s && !wr_n_d && !cs_n_d;
  assign wr_ch     = addr_d;
  assign wr_word   = data_d;
endmodule

// File: rtl/odr_channel.sv
module odr_channel #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              ld_active,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] out_q
);
  import octal_dac_pkg::*;

  logic [31:0] load_val;

  assign load_val = load_source(32'(stage_q), 32'(wr_word), hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (hit)       stage_q <= wr_word;
      if (ld_active) out_q   <= load_val[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/octal_dac_regif.sv
module octal_dac_regif #(
  parameter int DATA_W  = 14,
  parameter int NUM_CH  = 8,
  parameter int SYNC_N  = 2,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int FLAT_W = DATA_W * NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic [CH_W-1:0]   chan_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [FLAT_W-1:0] dac_code,
  output logic [NUM_CH-1:0] clr_flag
);
  import octal_dac_pkg::*;

  logic [3:0]        strobe_s;
  logic [CH_W-1:0]   addr_s;
  logic [DATA_W-1:0] data_s;

  logic              wr_commit;
  logic [CH_W-1:0]   wr_ch;
  logic [DATA_W-1:0] wr_word;
  logic              ld_active;
  logic              clr_active;
  logic [NUM_CH-1:0] wr_sel;
  logic [FLAT_W-1:0] stage_flat;

  odr_sync #(.W(4), .STAGES(SYNC_N), .RST_V(1'b1)) u_sync_strobe (
    .clk (clk), .rst (rst),
    .d   ({cs_n, wr_n, ld_n, clr_n}),
    .q   (strobe_s)
  );

  odr_sync #(.W(CH_W + DATA_W), .STAGES(SYNC_N), .RST_V(1'b0)) u_sync_bus (
    .clk (clk), .rst (rst),
    .d   ({chan_addr, wr_data}),
    .q   ({addr_s, data_s})
  );

  odr_write_detect #(.DATA_W(DATA_W), .CH_W(CH_W)) u_wdet (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (strobe_s[3]),
    .wr_n_s    (strobe_s[2]),
    .addr_s    (addr_s),
    .data_s    (data_s),
    .wr_commit (wr_commit),
    .wr_ch     (wr_ch),
    .wr_word   (wr_word)
  );

  assign ld_active  = !strobe_s[1];
  assign clr_active = !strobe_s[0];

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_ch
      assign wr_sel[i] = chan_hit(int'(wr_ch), i, wr_commit);

      odr_channel #(.DATA_W(DATA_W)) u_ch (
        .clk       (clk),
        .rst       (rst),
        .hit       (wr_sel[i]),
        .ld_active (ld_active),
        .wr_word   (wr_word),
        .stage_q   (stage_flat[i*DATA_W +: DATA_W]),
        .out_q     (dac_code[i*DATA_W +: DATA_W])
      );

      assign clr_flag[i] = clr_active;
    end
  endgenerate
endmodule

// File: rtl/octal_dac_regif_chk.sv
module octal_dac_regif_chk #(
  parameter int W    = 14,
  parameter int N    = 8,
  parameter int CH_W = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           clr_n,
  input logic           wr_commit,
  input logic [N-1:0]   wr_sel,
  input logic [CH_W-1:0] wr_ch,
  input logic [W-1:0]   wr_word,
  input logic           ld_active,
  input logic [W*N-1:0] stage_flat,
  input logic [W*N-1:0] dac_code,
  input logic [N-1:0]   clr_flag
);
  logic            fire_q;
  logic [CH_W-1:0] ch_q;
  logic [W-1:0]    word_q;
  logic [W-1:0]    code_at_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_q <= 1'b0;
      ch_q   <= '0;
      word_q <= '0;
    end else begin
      fire_q <= wr_commit && ld_active;
      ch_q   <= wr_ch;
      word_q <= wr_word;
    end
  end

  assign code_at_ch = dac_code[ch_q*W +: W];

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (dac_code == '0 && clr_flag == '0)); // R1
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst) wr_commit |-> $countones(wr_sel) == 1); // R2
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst) !wr_commit |=> $stable(stage_flat)); // R3
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst) !ld_active |=> $stable(dac_code)); // R4
  AST_CLEAR_FOLLOWS: assert property (@(posedge clk) disable iff (rst) clr_flag == {N{~$past(clr_n, 2)}}); // R7
  AST_FRESH_WINS: assert property (@(posedge clk) disable iff (rst) fire_q |-> code_at_ch == word_q); // R9
endmodule

bind octal_dac_regif octal_dac_regif_chk #(.W(DATA_W), .N(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_n      (clr_n),
  .wr_commit  (wr_commit),
  .wr_sel     (wr_sel),
  .wr_ch      (wr_ch),
  .wr_word    (wr_word),
  .ld_active  (ld_active),
  .stage_flat (stage_flat),
  .dac_code   (dac_code),
  .clr_flag   (clr_flag)
);

// File: tb/octal_dac_regif_test.sv
module octal_dac_regif_test;
  localparam int W = 14;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
  logic [2:0]   chan_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W*N-1:0] dac_code;
  logic [N-1:0]   clr_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_in  [N];
  logic [W-1:0] exp_out [N];

  always #2 clk = ~clk;

  octal_dac_regif uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n),
    .chan_addr(chan_addr), .wr_data(wr_data), .dac_code(dac_code), .clr_flag(clr_flag)
  );

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check_all(input string req, input logic [N-1:0] flag_exp);
    for (int c = 0; c < N; c++) begin
      checks++;
      if (dac_code[c*W +: W] !== exp_out[c]) begin
        errors++;
        $display("FAIL %s ch%0d code actual %h expected %h", req, c, dac_code[c*W +: W], exp_out[c]);
      end
    end
    checks++;
    if (clr_flag !== flag_exp) begin
      errors++;
      $display("FAIL %s clr_flag actual %b expected %b", req, clr_flag, flag_exp);
    end
  endtask

  task automatic do_write(input int ch, input logic [W-1:0] val, input logic sel_n);
    @(negedge clk);
    chan_addr = 3'(ch);
    wr_data   = val;
    cs_n      = sel_n;
    idle(3);
    wr_n = 1'b0;
    idle(3);
    wr_n = 1'b1;
    idle(3);
    cs_n = 1'b1;
    idle(3);
    if (!sel_n) begin
      exp_in[ch] = val;
      if (!ld_n) exp_out[ch] = val;
    end
  endtask

  task automatic do_load();
    @(negedge clk);
    ld_n = 1'b0;
    idle(3);
    ld_n = 1'b1;
    idle(4);
    for (int c = 0; c < N; c++) exp_out[c] = exp_in[c];
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin
      exp_in[c]  = '0;
      exp_out[c] = '0;
    end
    idle(4);
    check_all("R1 during reset", '0);
    rst = 1'b0;
    idle(2);
    check_all("R1 after reset", '0);

    // R2 R4: staged writes stay hidden until load
    for (int c = 0; c < N; c++) do_write(c, W'((c * 1234 + 77) & 16'h3fff), 1'b0);
    check_all("R4 no load yet", '0);
    do_load();
    check_all("R2 R4 global load", '0);

    // R3: write with select high is ignored
    do_write(3, 14'h2aaa, 1'b1);
    do_load();
    check_all("R3 deselected write", '0);

    // R7 R8: clear raises flags and keeps codes
    do_write(5, 14'h1555, 1'b0);
    @(negedge clk);
    clr_n = 1'b0;
    idle(4);
    check_all("R7 clear active", '1);
    clr_n = 1'b1;
    idle(4);
    check_all("R8 clear released", '0);
    do_load();
    check_all("R8 staging kept through clear", '0);

    // R5 R6: transparent mode, walking one over every channel and bit
    @(negedge clk);
    ld_n = 1'b0;
    idle(3);
    for (int c = 0; c < N; c++) begin
      for (int b = 0; b < W; b++) begin
        do_write(c, W'(1) << b, 1'b0);
        check_all("R5 R6 transparent walk", '0);
      end
    end
    @(negedge clk);
    ld_n = 1'b1;
    idle(3);

    // R9: one-cycle load aligned with the write's rising edge
    for (int c = 0; c < N; c++) begin
      @(negedge clk);
      chan_addr = 3'(c);
      wr_data   = W'(16'h3fff - c * 311);
      cs_n      = 1'b0;
      idle(3);
      wr_n = 1'b0;
      idle(3);
      wr_n = 1'b1;
      ld_n = 1'b0;
      @(negedge clk);
      ld_n = 1'b1;
      idle(2);
      cs_n = 1'b1;
      idle(4);
      exp_in[c] = W'(16'h3fff - c * 311);
      for (int k = 0; k < N; k++) exp_out[k] = exp_in[k];
      check_all("R9 coincident write and load", '0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule